// File: doc/BRIEF.md
# Two-Ratio Bit-Pixel Line Scaler

This block resamples a stream of one-bit pixels so that every M pixels that enter become N pixels that leave. Software supplies the two ratio values on static configuration inputs. A single signed decision term, held in a register, selects one of two stepping schemes. When M exceeds N the scaler shrinks the line: it drops pixels, consuming one input on every step and emitting one only on some steps. When N is at least M it stretches the line: it repeats pixels, emitting one output on every step and consuming an input only on some steps. The term is never formed as a fractional address.

Pixels enter and leave on valid/ready streams. The input stream's head is the pixel the scaler points at. Each emitted pixel is a copy of that head pixel. A one-cycle `line_start` pulse rearms the decision term at the start of every line. The same engine can also step whole rows for vertical scaling, in which case the host treats each "pixel" as a row-select event. A configuration outside the legal limits raises an error flag and holds the engine idle.

Top module: `pix_scaler`

## Requirements
- R1: `cfg_err` is 1 when either ratio value is 0 or above 127. While `cfg_err` is 1, `in_ready` and `out_valid` stay 0.
- R2: After reset, and until the first `line_start` with a legal configuration, `in_ready` and `out_valid` stay 0.
- R3: With M > N (shrink), input j of a line (counted from 0) is consumed on its own step. It is also emitted only when floor((j+1)·N/M) > floor(j·N/M). A line of L pixels therefore yields floor(L·N/M) outputs.
- R4: With N ≥ M (stretch), output k of a line carries input floor(k·M/N). The line yields ceil(L·N/M) outputs, and the last input is consumed together with its last copy.
- R5: With M = N, every input pixel passes to the output once, in order.
- R6: Every emitted pixel equals the input pixel selected in that cycle. The bench uses the pixel level directly, with 1 and 0 as the two colours.
- R7: Gaps in `in_valid` and deasserted `out_ready` freeze the decision term. The output sequence is then identical to the one produced with no stalls.
- R8: `line_start` rearms the term regardless of where the previous line stopped. During the pulse cycle, no transfer takes place.
- R9: With M = 6 and N = 1, a 3300-pixel line yields 550 pixels. Each one is the last pixel of its group of six.
- R10: `cfg_err` is 1 when |M − N| > 64. A pair whose difference is exactly 64 is legal and scales correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_m | input | CFG_W | Input pixels per ratio period (M) |
| cfg_n | input | CFG_W | Output pixels per ratio period (N) |
| line_start | input | 1 | One-cycle pulse that rearms the term for a new line |
| in_valid | input | 1 | Input pixel present |
| in_pix | input | 1 | Input pixel value |
| in_ready | output | 1 | Input pixel consumed this cycle |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | 1 | Output pixel value |
| out_ready | input | 1 | Downstream accepts the output |
| cfg_err | output | 1 | Ratio configuration is illegal |

## Verification
Two events can coincide in one cycle: consuming an input and emitting an output. In shrink mode this happens on every step where the term is non-negative. In stretch mode it happens on the step that advances the pointer. The bench provokes the coincidence with ratios such as 7/5 and 3/8. It also withholds `out_ready` on exactly those cycles, so that a wrong design either consumes an input whose copy is lost or emits a duplicate. The emitted stream is judged against index formulas computed in the bench, both for pixel count and for every pixel value.

// File: rtl/pix_scaler.sv
module pix_scaler #(
  parameter int CFG_W    = 8,
  parameter int MAX_MN   = 127,
  parameter int MAX_DIFF = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_m,
  input  logic [CFG_W-1:0] cfg_n,
  input  logic             line_start,
  input  logic             in_valid,
  input  logic             in_pix,
  output logic             in_ready,
  output logic             out_valid,
  output logic             out_pix,
  input  logic             out_ready,
  output logic             cfg_err
);
  localparam int TW = CFG_W + 2;
  localparam logic [CFG_W-1:0]     MN_LIM = CFG_W'(MAX_MN);
  localparam logic signed [TW-1:0] D_LIM  = TW'(MAX_DIFF);

  logic signed [TW-1:0] m_s, n_s, diff, mag, gain, term, term_nx;
  logic shrink, hit, live, step, run;

  assign m_s    = $signed({2'b00, cfg_m});
  assign n_s    = $signed({2'b00, cfg_n});
  assign diff   = m_s - n_s;
  assign shrink = diff > 0;
  assign mag    = shrink ? diff : -diff;
  assign gain   = shrink ? n_s : m_s;

  assign cfg_err = (cfg_m == '0) || (cfg_n == '0) || (cfg_m > MN_LIM) ||
                   (cfg_n > MN_LIM) || (mag > D_LIM);

  assign hit  = ~term[TW-1];
  assign live = run & ~cfg_err & ~line_start;

  assign out_pix   = in_pix;
  assign out_valid = live & in_valid & (shrink ? hit : 1'b1);
  assign in_ready  = live & (shrink ? (~hit | out_ready) : (hit & out_ready));
  assign step      = live & in_valid & (shrink ? (~hit | out_ready) : out_ready);
  assign term_nx   = hit ? term - mag : term + gain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      term <= '0;
    end else if (line_start) begin
      run  <= ~cfg_err;
      term <= -mag;
    end else if (step) begin
      term <= term_nx;
    end
  end
endmodule

// File: rtl/scaler_chk.sv
module scaler_chk #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CFG_W-1:0] cfg_m,
  input logic [CFG_W-1:0] cfg_n,
  input logic             line_start,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             cfg_err
);
  logic       shrink;
  logic [7:0] run_cnt;
  assign shrink = cfg_m > cfg_n;

  always_ff @(posedge clk) begin
    if (!rst_n || line_start) run_cnt <= '0;
    else if (shrink) begin
      if (in_valid && in_ready) run_cnt <= (out_valid && out_ready) ? '0 : run_cnt + 8'd1;
    end else begin
      if (out_valid && out_ready) run_cnt <= (in_valid && in_ready) ? '0 : run_cnt + 8'd1;
    end
  end

  a_r1_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!in_ready && !out_valid));
  a_r8_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> (!in_ready && !out_valid));
  a_r3_emit_consumes: assert property (@(posedge clk) disable iff (!rst_n || cfg_err)
    (shrink && out_valid && out_ready) |-> in_ready);
  a_r4_consume_emits: assert property (@(posedge clk) disable iff (!rst_n || cfg_err)
    (!shrink && in_valid && in_ready) |-> (out_valid && out_ready));
  a_r7_hold_output: assert property (@(posedge clk) disable iff (!rst_n || cfg_err)
    (out_valid && !out_ready) |=> (line_start || !in_valid || out_valid));
  a_r3_drop_run: assert property (@(posedge clk) disable iff (!rst_n || cfg_err || line_start)
    shrink |-> (int'(run_cnt) * int'(cfg_n) < int'(cfg_m)));
  a_r4_repeat_run: assert property (@(posedge clk) disable iff (!rst_n || cfg_err || line_start)
    !shrink |-> (int'(run_cnt) * int'(cfg_m) < int'(cfg_n)));
endmodule

bind pix_scaler scaler_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_m(cfg_m), .cfg_n(cfg_n),
  .line_start(line_start), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .cfg_err(cfg_err)
);

// File: tb/test_pix_scaler.sv
module test_pix_scaler;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] cfg_m = 8'd1, cfg_n = 8'd1;
  logic line_start = 1'b0, in_valid = 1'b0, in_pix = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, out_pix, cfg_err;
  int checks = 0, fails = 0, cyc = 0;

  pix_scaler i_pix_scaler (
    .clk(clk), .rst_n(rst_n), .cfg_m(cfg_m), .cfg_n(cfg_n),
    .line_start(line_start), .in_valid(in_valid), .in_pix(in_pix),
    .in_ready(in_ready), .out_valid(out_valid), .out_pix(out_pix),
    .out_ready(out_ready), .cfg_err(cfg_err)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic pat(input int i);
    return ((i * 5 + i / 7) % 3) == 0;
  endfunction

  task automatic run_line(input int m, input int n, input int len, input bit gaps, input string req);
    int ip = 0, op = 0, bad = 0, guard = 0, first = -1, expc, idx;
    bit hold = 0, shrink;
    shrink = m > n;
    expc = shrink ? (len * n) / m : (len * n + m - 1) / m;
    @(negedge clk);
    cfg_m = 8'(m); cfg_n = 8'(n); line_start = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    line_start = 1'b0;
    while (ip < len && guard < 40000) begin
      guard++;
      in_valid  = !(gaps && (guard % 3 == 1) && !hold);
      in_pix    = pat(ip);
      out_ready = !(gaps && (guard % 4 == 2));
      #1;
      if (out_valid && out_ready) begin
        idx = shrink ? ((op + 1) * m + n - 1) / n - 1 : (op * m) / n;
        if (out_pix !== pat(idx)) begin
          if (first < 0) first = op;
          bad++;
        end
        op++;
      end
      if (in_valid && in_ready) begin ip++; hold = 0; end
      else hold = in_valid;
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    check(op == expc, req, $sformatf("output count M=%0d N=%0d", m, n), op, expc);
    check(bad == 0, "R6", $sformatf("pixel mismatches M=%0d N=%0d first at %0d", m, n, first), bad, 0);
  endtask

  task automatic t_reset_idle;
    @(negedge clk);
    in_valid = 1'b1;
    #1;
    check(!in_ready && !out_valid, "R2", "idle before first line_start", {in_ready, out_valid}, 0);
    @(negedge clk);
    #1;
    check(!in_ready && !out_valid, "R2", "idle second cycle", {in_ready, out_valid}, 0);
    in_valid = 1'b0;
  endtask

  task automatic t_bad_cfg(input int m, input int n, input string req);
    @(negedge clk);
    cfg_m = 8'(m); cfg_n = 8'(n); line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0; in_valid = 1'b1;
    #1;
    check(cfg_err == 1'b1, req, $sformatf("cfg_err for M=%0d N=%0d", m, n), cfg_err, 1);
    check(!in_ready && !out_valid, "R1", "idle under bad config", {in_ready, out_valid}, 0);
    in_valid = 1'b0;
  endtask

  task automatic t_good_edge;
    @(negedge clk);
    cfg_m = 8'd127; cfg_n = 8'd63;
    #1;
    check(cfg_err == 1'b0, "R10", "difference 64 legal", cfg_err, 0);
    run_line(127, 63, 400, 1'b1, "R10");
    run_line(63, 127, 200, 1'b0, "R10");
  endtask

  task automatic t_restart;
    run_line(6, 1, 4, 1'b0, "R8");
    run_line(6, 1, 12, 1'b0, "R8");
    run_line(1, 3, 1, 1'b1, "R8");
    run_line(1, 3, 5, 1'b0, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_idle();
    rst_n = 1'b1;
    t_reset_idle();
    t_bad_cfg(0, 5, "R1");
    t_bad_cfg(5, 0, "R1");
    t_bad_cfg(128, 100, "R1");
    t_bad_cfg(100, 20, "R10");
    t_good_edge();
    run_line(6, 1, 3300, 1'b0, "R9");
    run_line(7, 5, 500, 1'b0, "R3");
    run_line(7, 5, 500, 1'b1, "R7");
    run_line(3, 8, 300, 1'b0, "R4");
    run_line(3, 8, 300, 1'b1, "R7");
    run_line(1, 3, 100, 1'b1, "R4");
    run_line(50, 50, 200, 1'b1, "R5");
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule